// File: doc/BRIEF.md
# I2C Controller Status Flag Register

This block is the status byte of an I2C controller. A separate bus engine reports what happens on the bus as single-cycle event pulses: start generated, start detected, stop detected, arbitration lost, the rising edge of the eighth SCL clock together with the received address byte and an address-hit qualifier, and the ninth-clock acknowledge sample. It also supplies a level that gives the transfer direction. The block turns these pulses into eight sticky flags. Each flag has its own set and clear conditions.

A host reads the flags through a read port that is always visible. The read strobe returns the value held in the current cycle. Reading clears the arbitration-lost flag on the following clock. A host release command and a falling edge of the controller enable clear the session flags. The falling edge of the enable clears every flag. A synchronous active-high reset returns the byte to 00h.

Top module: `i2c_stat_reg`

## Requirements
- R1: After a synchronous reset, `rd_data` reads 00h, and this holds for a reset asserted in the middle of a session.
- R2: `rd_data` always shows the flag byte: bit 7 master, bit 6 arbitration lost, bit 5 extension code, bit 4 address match, bit 3 transmit, bit 2 acknowledge, bit 1 start seen, bit 0 stop seen. In the cycle where `rd_strobe` is high it returns the value held before any clear.
- R3: The master flag sets on `ev_start_gen`. It clears on a detected stop, an arbitration loss, `host_release` or an enable fall. When a set and a clear come in the same cycle, the clear wins.
- R4: `ev_arb_lost` sets the arbitration flag and forces the master flag to 0 at the same edge.
- R5: The arbitration flag clears at the clock edge that ends a cycle with `rd_strobe` high. If `ev_arb_lost` comes in that same cycle, the flag stays set.
- R6: On `ev_clk8_rise`, the extension flag sets only when `rx_byte[7:4]` is 4'b0000 or 4'b1111. Any other upper nibble leaves it unchanged.
- R7: The extension flag and the address-match flag clear on a detected start, a detected stop, `host_release` or an enable fall.
- R8: The address-match flag sets on `ev_clk8_rise` when `addr_hit` is high.
- R9: At each clock, the transmit flag takes the value of `dir_tx` if the master flag or the address-match flag is set at that clock. Otherwise it takes 0.
- R10: The acknowledge flag loads `ack_sample` on an `ev_clk9` pulse and holds its value otherwise.
- R11: A detected start sets the start-seen flag and clears the stop-seen flag. A detected stop does the reverse.
- R12: A 1-to-0 transition of `ctl_en` clears all eight flags in one cycle. While `ctl_en` stays low afterwards, flags can be set again and are not cleared again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_en | input | 1 | Controller enable level |
| host_release | input | 1 | Host command to leave the current session |
| rd_strobe | input | 1 | Host read of the status byte |
| ev_start_gen | input | 1 | Controller generated a start |
| ev_start_det | input | 1 | Start condition seen on the bus |
| ev_stop_det | input | 1 | Stop condition seen on the bus |
| ev_arb_lost | input | 1 | Arbitration lost |
| ev_clk8_rise | input | 1 | Eighth SCL rising edge of an address byte |
| rx_byte | input | 8 | Received address byte |
| addr_hit | input | 1 | Own address matched (qualifies ev_clk8_rise) |
| ev_clk9 | input | 1 | Ninth clock, acknowledge sampled |
| ack_sample | input | 1 | Sampled acknowledge value |
| dir_tx | input | 1 | Transfer direction, 1 means transmit |
| rd_data | output | 8 | Status byte |

## Verification
A table of bus events drives one master session and one slave session. The master session is a start followed by data. The slave session is an address byte and then a release. The arbitration sequences cover a plain loss, a read on its own, and a loss that lands in the same cycle as a read. This separates clear-wins priority from set-wins priority. The address bytes use nibbles 0000, 1111, 0101 and 0111, so an extension decode that accepts only one code, or any code, shows up as an error. Directed cases cover the value returned during a read, a single enable fall followed by flags set while the enable is held low, and a reset in the middle of a session.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;

    localparam int STAT_W  = 8;
    localparam int BYTE_W  = 8;
    localparam int NIB_W   = 4;
    localparam logic [NIB_W-1:0] EXT_LO = '0;
    localparam logic [NIB_W-1:0] EXT_HI = '1;

    // Flag byte, MSB first: the field order is the host-visible bit layout.
    typedef struct packed {
        logic master;
        logic arb;
        logic ext;
        logic match;
        logic trc;
        logic ack;
        logic std;
        logic spd;
    } stat_t;

    typedef struct packed {
        logic start_gen;
        logic start_det;
        logic stop_det;
        logic arb_lost;
        logic clk8;
        logic addr_hit;
        logic clk9;
        logic ack;
        logic dir;
        logic release_cmd;
        logic rd;
    } evt_t;

    function automatic logic is_ext_code(input logic [BYTE_W-1:0] b);
        logic [NIB_W-1:0] hi;
        hi = b[BYTE_W-1 -: NIB_W];
        return (hi == EXT_LO) || (hi == EXT_HI);
    endfunction

endpackage

// File: rtl/i2c_stat_enfall.sv
module i2c_stat_enfall (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic fall
);
    logic en_q;

    always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= en;
    end

    assign fall = en_q & ~en;

    // R12
    fall_once_chk: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall);

endmodule

// File: rtl/i2c_stat_flags.sv
module i2c_stat_flags
    import i2c_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en_fall,
    input  evt_t              ev,
    input  logic [BYTE_W-1:0] rx_byte,
    output stat_t             fl
);
    stat_t nx;
    logic  clr_sess;
    logic  clr_addr;

    assign clr_sess = ev.stop_det | ev.arb_lost | ev.release_cmd | en_fall;
    assign clr_addr = ev.start_det | ev.stop_det | ev.release_cmd | en_fall;

    always_comb begin
        nx = fl;
        if (clr_sess)          nx.master = 1'b0;
        else if (ev.start_gen) nx.master = 1'b1;

        if (en_fall)           nx.arb = 1'b0;
        else if (ev.arb_lost)  nx.arb = 1'b1;
        else if (ev.rd)        nx.arb = 1'b0;

        if (clr_addr)                              nx.ext = 1'b0;
        else if (ev.clk8 && is_ext_code(rx_byte))  nx.ext = 1'b1;

        if (clr_addr)                      nx.match = 1'b0;
        else if (ev.clk8 && ev.addr_hit)   nx.match = 1'b1;

        if (en_fall)                    nx.trc = 1'b0;
        else if (fl.master || fl.match) nx.trc = ev.dir;
        else                            nx.trc = 1'b0;

        if (en_fall)      nx.ack = 1'b0;
        else if (ev.clk9) nx.ack = ev.ack;

        if (en_fall) begin
            nx.std = 1'b0;
            nx.spd = 1'b0;
        end else if (ev.start_det) begin
            nx.std = 1'b1;
            nx.spd = 1'b0;
        end else if (ev.stop_det) begin
            nx.std = 1'b0;
            nx.spd = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) fl <= '0;
        else     fl <= nx;
    end

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> (fl == '0));

    // R4
    arb_forces_slave_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.arb_lost && !en_fall) |=> (fl.arb && !fl.master));

    // R5
    read_clears_arb_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.rd && !ev.arb_lost) |=> !fl.arb);

    // R3
    start_gen_master_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.start_gen && !ev.stop_det && !ev.arb_lost && !ev.release_cmd && !en_fall)
        |=> fl.master);

    // R11
    stop_seen_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.stop_det && !ev.start_det && !en_fall) |=> (fl.spd && !fl.std));

    // R12
    disable_clears_all_chk: assert property (@(posedge clk) disable iff (rst)
        en_fall |=> (fl == '0));

endmodule

// File: rtl/i2c_stat_reg.sv
module i2c_stat_reg
    import i2c_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_en,
    input  logic              host_release,
    input  logic              rd_strobe,
    input  logic              ev_start_gen,
    input  logic              ev_start_det,
    input  logic              ev_stop_det,
    input  logic              ev_arb_lost,
    input  logic              ev_clk8_rise,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              addr_hit,
    input  logic              ev_clk9,
    input  logic              ack_sample,
    input  logic              dir_tx,
    output logic [STAT_W-1:0] rd_data
);
    logic  en_fall;
    evt_t  ev;
    stat_t fl;

    assign ev = '{start_gen:   ev_start_gen,
                  start_det:   ev_start_det,
                  stop_det:    ev_stop_det,
                  arb_lost:    ev_arb_lost,
                  clk8:        ev_clk8_rise,
                  addr_hit:    addr_hit,
                  clk9:        ev_clk9,
                  ack:         ack_sample,
                  dir:         dir_tx,
                  release_cmd: host_release,
                  rd:          rd_strobe};

    i2c_stat_enfall u_enfall (
        .clk  (clk),
        .rst  (rst),
        .en   (ctl_en),
        .fall (en_fall)
    );

    i2c_stat_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .en_fall (en_fall),
        .ev      (ev),
        .rx_byte (rx_byte),
        .fl      (fl)
    );

    assign rd_data = fl;

    // R2
    read_port_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!ev_start_gen && !ev_start_det && !ev_stop_det && !ev_arb_lost &&
         !ev_clk8_rise && !ev_clk9 && !host_release && !rd_strobe && !en_fall &&
         !rd_data[7] && !rd_data[4]) |=> (rd_data[7:4] == $past(rd_data[7:4])));

endmodule

// File: tb/i2c_stat_reg_test.sv
module i2c_stat_reg_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_en = 1'b0, host_release = 1'b0, rd_strobe = 1'b0;
    logic       ev_start_gen = 1'b0, ev_start_det = 1'b0, ev_stop_det = 1'b0;
    logic       ev_arb_lost = 1'b0, ev_clk8_rise = 1'b0, addr_hit = 1'b0;
    logic       ev_clk9 = 1'b0, ack_sample = 1'b0, dir_tx = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    i2c_stat_reg uut (
        .clk(clk), .rst(rst), .ctl_en(ctl_en), .host_release(host_release),
        .rd_strobe(rd_strobe), .ev_start_gen(ev_start_gen),
        .ev_start_det(ev_start_det), .ev_stop_det(ev_stop_det),
        .ev_arb_lost(ev_arb_lost), .ev_clk8_rise(ev_clk8_rise),
        .rx_byte(rx_byte), .addr_hit(addr_hit), .ev_clk9(ev_clk9),
        .ack_sample(ack_sample), .dir_tx(dir_tx), .rd_data(rd_data)
    );

    // ctrl bits: en rel rd sg sd sp al c8 hit c9 ack dir | rx_byte | expected
    localparam int NV = 22;
    localparam logic [27:0] VEC [NV] = '{
        {12'b1000_0000_0000, 8'h00, 8'h00},  // idle
        {12'b1000_1000_0000, 8'h00, 8'h02},  // R11 start seen
        {12'b1001_0000_0000, 8'h00, 8'h82},  // R3 master set
        {12'b1000_0000_0001, 8'h00, 8'h8A},  // R9 trc follows dir as master
        {12'b1000_0001_0001, 8'h0A, 8'hAA},  // R6 nibble 0000
        {12'b1000_0000_0111, 8'h00, 8'hAE},  // R10 ack loaded 1
        {12'b1000_0100_0001, 8'h00, 8'h0D},  // R3 R7 R11 stop
        {12'b1000_0000_0001, 8'h00, 8'h05},  // R9 trc drops
        {12'b1000_1000_0000, 8'h00, 8'h06},  // R11 start clears stop
        {12'b1000_0001_0000, 8'hF3, 8'h26},  // R6 nibble 1111
        {12'b1000_0001_1000, 8'h53, 8'h36},  // R8 match, ext held
        {12'b1000_0000_0000, 8'h00, 8'h36},  // R9 dir 0
        {12'b1000_0000_0001, 8'h00, 8'h3E},  // R9 trc as slave
        {12'b1100_0000_0001, 8'h00, 8'h0E},  // R7 release
        {12'b1000_0000_0000, 8'h00, 8'h06},  // R9 trc cleared
        {12'b1001_0000_0000, 8'h00, 8'h86},  // R3
        {12'b1000_0010_0000, 8'h00, 8'h46},  // R4 arb loss
        {12'b1010_0000_0000, 8'h00, 8'h06},  // R5 read clears
        {12'b1010_0010_0000, 8'h00, 8'h46},  // R5 set wins
        {12'b1010_0000_0000, 8'h00, 8'h06},  // R5
        {12'b1000_0001_0000, 8'h78, 8'h06},  // R6 nibble 0111 ignored
        {12'b1000_0000_0100, 8'h00, 8'h02}   // R10 ack loaded 0
    };

    task automatic drive(input logic [11:0] c, input logic [7:0] rx);
        {ctl_en, host_release, rd_strobe, ev_start_gen, ev_start_det, ev_stop_det,
         ev_arb_lost, ev_clk8_rise, addr_hit, ev_clk9, ack_sample, dir_tx} = c;
        rx_byte = rx;
    endtask

    task automatic check(input logic [7:0] exp, input string req);
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s: rd_data=%h expected=%h", req, rd_data, exp);
        end
    endtask

    task automatic step(input logic [11:0] c, input logic [7:0] rx,
                        input logic [7:0] exp, input string req);
        drive(c, rx);
        @(negedge clk);
        check(exp, req);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        check(8'h00, "R1 reset");
        rst = 1'b0;
        for (int i = 0; i < NV; i++)
            step(VEC[i][27:16], VEC[i][15:8], VEC[i][7:0], "table R2-R11");

        // R2 value before clear, then R5 clear after the edge
        step(12'b1000_0010_0000, 8'h00, 8'h42, "R4");
        drive(12'b1010_0000_0000, 8'h00);
        #1 check(8'h42, "R2 read returns pre-clear value");
        @(negedge clk);
        check(8'h02, "R5 cleared after read");

        // R12 enable fall clears once
        step(12'b1001_0000_0000, 8'h00, 8'h82, "R3");
        step(12'b0000_0000_0000, 8'h00, 8'h00, "R12 enable fall");
        step(12'b0000_1000_0000, 8'h00, 8'h02, "R12 set while low");
        step(12'b0000_0000_0000, 8'h00, 8'h02, "R12 no repeated clear");
        step(12'b1000_0000_0000, 8'h00, 8'h02, "R12 re-enable");

        // R3 clear wins over start generation
        step(12'b1001_0100_0000, 8'h00, 8'h01, "R3 clear wins");

        // R1 mid-session reset
        step(12'b1001_0000_0000, 8'h00, 8'h81, "R3");
        rst = 1'b1;
        @(negedge clk);
        check(8'h00, "R1 mid-session reset");
        rst = 1'b0;
        drive(12'b0, 8'h00);
        done = 1'b1;
    end

    initial begin
        for (int n = 0; n < 5000 && !done; n++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: rd_data=%h expected=completion", rd_data);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule